// File: doc/BRIEF.md
# Subframe Strobe Generator

This block divides a physical subframe into chip, bit and byte slots and tells the rest of the modem where the line currently is within that subframe. A free-running chip counter advances once per chip-rate enable and wraps at the end of each subframe. Registered single-cycle strobes decoded from the counter mark the start of each bit, byte and subframe. The chip rate is eight times the line bit rate.

Two early-warning strobes fire a fixed lead of chips ahead of each byte boundary and ahead of the subframe boundary. A local controller uses them as interrupts, so it has time to prepare the next byte or frame. The lead-ahead wraps across the end of the subframe, so the warning for the byte and frame at count 0 comes at the end of the previous subframe. A level signal is high between the frame warning and the frame start. It can be routed to a shared output pin for an external host, or the pin can carry transmit data instead. Switching between transmit and receive never disturbs the counter, so both directions share one timing phase.

Top module: `subframe_strobe_gen`

## Requirements
- R1: `chipCount` resets to 0 and advances by one on every clock edge with `chipEn` high. After SUBFRAME_CHIPS-1 (2879 by default) the next value is 0.
- R2: `bitStb` is high exactly while `chipCount` is a multiple of 8.
- R3: `byteStb` is high exactly while `chipCount` is a multiple of 64 (0, 64, … 2816).
- R4: `frameStb` is high exactly while `chipCount` is 0, except in the reset state.
- R5: `preByteStb` is high exactly while `chipCount` plus 8, taken modulo 2880, is a multiple of 64. That gives 56, 120, … 2808 and 2872, and no other value.
- R6: `preFrameStb` is high exactly while `chipCount` is 2872.
- R7: `preSlot` goes high on the edge that raises `preFrameStb` and goes low on the edge that raises `frameStb`. It holds its value at all other times, so it is high for counts 2872 through 2879.
- R8: While `slotPinDisable` is 0, `sharedPin` equals `preSlot`.
- R9: While `slotPinDisable` is 1, `sharedPin` equals `txData` when `txMode` is 1 and is 0 when `txMode` is 0.
- R10: A change of `txMode` has no effect on `chipCount` or on any strobe.
- R11: On an edge with `chipEn` low, `chipCount`, all strobes and `preSlot` keep their values.
- R12: A synchronous `rst` sets `chipCount` to 0 and drives every strobe and `preSlot` to 0 on the same edge, whatever `chipEn` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chipEn | input | 1 | Chip-rate enable, one pulse per chip |
| txMode | input | 1 | 1 = transmit, 0 = receive |
| slotPinDisable | input | 1 | 0 routes `preSlot` to `sharedPin`; 1 routes transmit data |
| txData | input | 1 | Transmit data bit for the shared pin |
| chipCount | output | CNT_W (12) | Current chip position in the subframe |
| bitStb | output | 1 | Bit boundary strobe |
| byteStb | output | 1 | Byte boundary strobe |
| frameStb | output | 1 | Subframe start strobe |
| preByteStb | output | 1 | Early warning 8 chips before a byte boundary |
| preFrameStb | output | 1 | Early warning 8 chips before the subframe start |
| preSlot | output | 1 | Level from frame warning to frame start |
| sharedPin | output | 1 | Muxed output pin |

## Verification
`chipCount`, the five strobes and `preSlot` take their new values on the same enabled edge, with no added latency. The bench therefore advances its arithmetic model at each rising edge and compares at the following falling edge. `sharedPin` is combinational from the current inputs and `preSlot`, so it is compared at that same falling edge against the inputs driven half a cycle earlier. The stimulus runs more than two full subframes under an irregular enable pattern. It includes an idle stretch, a reset taken in mid-count, and mode and pin-select toggles at unrelated periods, so every strobe position, including the wrap at 2872 through 0, is compared every cycle.

// File: rtl/sfs_pkg.sv
package sfs_pkg;
  typedef struct packed {
    logic bitS;
    logic byteS;
    logic frameS;
    logic preByteS;
    logic preFrameS;
  } strobe_t;
endpackage

// File: rtl/sfs_decode.sv
// Control: decodes the count that will be loaded next into a strobe set.
module sfs_decode
  import sfs_pkg::*;
#(
  parameter int CHIPS_PER_BIT  = 8,
  parameter int BITS_PER_BYTE  = 8,
  parameter int SUBFRAME_CHIPS = 2880,
  parameter int LEAD_CHIPS     = 8,
  parameter int CNT_W          = 12
) (
  input  logic [CNT_W-1:0] nextCount,
  output strobe_t          stbNext
);
  localparam int CHIPS_PER_BYTE = CHIPS_PER_BIT * BITS_PER_BYTE;

  int unsigned curIdx;
  int unsigned aheadIdx;

  always_comb begin
    curIdx   = 32'(nextCount);
    aheadIdx = curIdx + LEAD_CHIPS;
    if (aheadIdx >= SUBFRAME_CHIPS) aheadIdx = aheadIdx - SUBFRAME_CHIPS;
    stbNext.bitS      = (curIdx % CHIPS_PER_BIT) == 0;
    stbNext.byteS     = (curIdx % CHIPS_PER_BYTE) == 0;
    stbNext.frameS    = curIdx == 0;
    stbNext.preByteS  = (aheadIdx % CHIPS_PER_BYTE) == 0;
    stbNext.preFrameS = aheadIdx == 0;
  end
endmodule

// File: rtl/sfs_datapath.sv
// Datapath: chip counter, strobe registers and slot level.
module sfs_datapath
  import sfs_pkg::*;
#(
  parameter int SUBFRAME_CHIPS = 2880,
  parameter int CNT_W          = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             chipEn,
  input  strobe_t          stbNext,
  output logic [CNT_W-1:0] nextCount,
  output logic [CNT_W-1:0] count,
  output strobe_t          stb,
  output logic             slot
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SUBFRAME_CHIPS - 1);

  assign nextCount = (count == LAST) ? '0 : count + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      stb   <= '0;
      slot  <= 1'b0;
    end else if (chipEn) begin
      count <= nextCount;
      stb   <= stbNext;
      if (stbNext.preFrameS)   slot <= 1'b1;
      else if (stbNext.frameS) slot <= 1'b0;
    end
  end
endmodule

// File: rtl/sfs_pin_sel.sv
// Shared pin routing.
module sfs_pin_sel (
  input  logic slot,
  input  logic slotPinDisable,
  input  logic txMode,
  input  logic txData,
  output logic pin
);
  always_comb begin
    if (!slotPinDisable) pin = slot;
    else                 pin = txMode & txData;
  end
endmodule

// File: rtl/subframe_strobe_gen.sv
module subframe_strobe_gen
  import sfs_pkg::*;
#(
  parameter  int CHIPS_PER_BIT  = 8,
  parameter  int BITS_PER_BYTE  = 8,
  parameter  int SUBFRAME_CHIPS = 2880,
  parameter  int LEAD_CHIPS     = 8,
  localparam int CNT_W          = $clog2(SUBFRAME_CHIPS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             chipEn,
  input  logic             txMode,
  input  logic             slotPinDisable,
  input  logic             txData,
  output logic [CNT_W-1:0] chipCount,
  output logic             bitStb,
  output logic             byteStb,
  output logic             frameStb,
  output logic             preByteStb,
  output logic             preFrameStb,
  output logic             preSlot,
  output logic             sharedPin
);
  strobe_t          stbNext;
  strobe_t          stbNow;
  logic [CNT_W-1:0] nextCount;

  sfs_decode #(
    .CHIPS_PER_BIT (CHIPS_PER_BIT),
    .BITS_PER_BYTE (BITS_PER_BYTE),
    .SUBFRAME_CHIPS(SUBFRAME_CHIPS),
    .LEAD_CHIPS    (LEAD_CHIPS),
    .CNT_W         (CNT_W)
  ) uDecode (
    .nextCount(nextCount),
    .stbNext  (stbNext)
  );

  sfs_datapath #(
    .SUBFRAME_CHIPS(SUBFRAME_CHIPS),
    .CNT_W         (CNT_W)
  ) uPath (
    .clk      (clk),
    .rst      (rst),
    .chipEn   (chipEn),
    .stbNext  (stbNext),
    .nextCount(nextCount),
    .count    (chipCount),
    .stb      (stbNow),
    .slot     (preSlot)
  );

  sfs_pin_sel uPin (
    .slot          (preSlot),
    .slotPinDisable(slotPinDisable),
    .txMode        (txMode),
    .txData        (txData),
    .pin           (sharedPin)
  );

  assign bitStb      = stbNow.bitS;
  assign byteStb     = stbNow.byteS;
  assign frameStb    = stbNow.frameS;
  assign preByteStb  = stbNow.preByteS;
  assign preFrameStb = stbNow.preFrameS;
endmodule

// File: rtl/sfs_checker.sv
module sfs_checker #(
  parameter int CHIPS_PER_BIT  = 8,
  parameter int BITS_PER_BYTE  = 8,
  parameter int SUBFRAME_CHIPS = 2880,
  parameter int LEAD_CHIPS     = 8,
  parameter int CNT_W          = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             chipEn,
  input logic             txMode,
  input logic             slotPinDisable,
  input logic             txData,
  input logic [CNT_W-1:0] chipCount,
  input logic             bitStb,
  input logic             byteStb,
  input logic             frameStb,
  input logic             preByteStb,
  input logic             preFrameStb,
  input logic             preSlot,
  input logic             sharedPin
);
  localparam int CHIPS_PER_BYTE = CHIPS_PER_BIT * BITS_PER_BYTE;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SUBFRAME_CHIPS - 1);
  localparam logic [CNT_W-1:0] PRE_FRAME_AT = CNT_W'(SUBFRAME_CHIPS - LEAD_CHIPS);

  p_wrap_r1: assert property (@(posedge clk) disable iff (rst)
    (chipEn && chipCount == LAST) |=> chipCount == '0);

  p_advance_r1_r10: assert property (@(posedge clk) disable iff (rst)
    (chipEn && chipCount != LAST) |=> chipCount == $past(chipCount) + CNT_W'(1));

  p_bit_align_r2: assert property (@(posedge clk) disable iff (rst)
    bitStb |-> (32'(chipCount) % CHIPS_PER_BIT) == 0);

  p_byte_align_r3: assert property (@(posedge clk) disable iff (rst)
    byteStb |-> (bitStb && (32'(chipCount) % CHIPS_PER_BYTE) == 0));

  p_frame_zero_r4: assert property (@(posedge clk) disable iff (rst)
    frameStb |-> (chipCount == '0 && byteStb));

  p_preframe_pos_r6: assert property (@(posedge clk) disable iff (rst)
    preFrameStb |-> (chipCount == PRE_FRAME_AT && preByteStb));

  p_slot_rise_r7: assert property (@(posedge clk) disable iff (rst)
    preFrameStb |-> preSlot);

  p_slot_fall_r7: assert property (@(posedge clk) disable iff (rst)
    frameStb |-> !preSlot);

  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !chipEn |=> ($stable(chipCount) && $stable(preSlot) && $stable(bitStb)
                 && $stable(preByteStb) && $stable(frameStb)));

  p_reset_r12: assert property (@(posedge clk)
    rst |=> (chipCount == '0 && !bitStb && !byteStb && !frameStb && !preSlot));

  always_comb begin
    if (!rst && !slotPinDisable)
      p_pin_slot_r8: assert (sharedPin == preSlot);
    if (!rst && slotPinDisable)
      p_pin_data_r9: assert (sharedPin == (txMode & txData));
  end
endmodule

bind subframe_strobe_gen sfs_checker #(
  .CHIPS_PER_BIT (CHIPS_PER_BIT),
  .BITS_PER_BYTE (BITS_PER_BYTE),
  .SUBFRAME_CHIPS(SUBFRAME_CHIPS),
  .LEAD_CHIPS    (LEAD_CHIPS),
  .CNT_W         (CNT_W)
) uChecker (
  .clk           (clk),
  .rst           (rst),
  .chipEn        (chipEn),
  .txMode        (txMode),
  .slotPinDisable(slotPinDisable),
  .txData        (txData),
  .chipCount     (chipCount),
  .bitStb        (bitStb),
  .byteStb       (byteStb),
  .frameStb      (frameStb),
  .preByteStb    (preByteStb),
  .preFrameStb   (preFrameStb),
  .preSlot       (preSlot),
  .sharedPin     (sharedPin)
);

// File: tb/subframe_strobe_gen_test.sv
module subframe_strobe_gen_test;
  localparam int SUB  = 2880;
  localparam int LEAD = 8;

  logic clk = 1'b0;
  logic rst, chipEn, txMode, slotPinDisable, txData;
  logic [11:0] chipCount;
  logic bitStb, byteStb, frameStb, preByteStb, preFrameStb, preSlot, sharedPin;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  subframe_strobe_gen uut (
    .clk(clk), .rst(rst), .chipEn(chipEn), .txMode(txMode),
    .slotPinDisable(slotPinDisable), .txData(txData),
    .chipCount(chipCount), .bitStb(bitStb), .byteStb(byteStb),
    .frameStb(frameStb), .preByteStb(preByteStb), .preFrameStb(preFrameStb),
    .preSlot(preSlot), .sharedPin(sharedPin)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d time=%0t", tag, act, exp, $time);
    end
  endtask

  // arithmetic model
  int  eCnt;
  bit  eBit, eByte, eFrame, ePreByte, ePreFrame, eSlot, ePin;

  task automatic modelReset();
    eCnt = 0; eBit = 0; eByte = 0; eFrame = 0; ePreByte = 0; ePreFrame = 0; eSlot = 0;
  endtask

  task automatic modelAdvance();
    eCnt      = (eCnt + 1) % SUB;
    eBit      = (eCnt % 8) == 0;
    eByte     = (eCnt % 64) == 0;
    eFrame    = eCnt == 0;
    ePreByte  = (((eCnt + LEAD) % SUB) % 64) == 0;
    ePreFrame = ((eCnt + LEAD) % SUB) == 0;
    if (ePreFrame)   eSlot = 1;
    else if (eFrame) eSlot = 0;
  endtask

  task automatic compareAll(input string cntTag);
    ePin = !slotPinDisable ? eSlot : (txMode & txData);
    chk(int'(chipCount) == eCnt, cntTag, int'(chipCount), eCnt);
    chk(bitStb == eBit, "R2 bitStb", int'(bitStb), int'(eBit));
    chk(byteStb == eByte, "R3 byteStb", int'(byteStb), int'(eByte));
    chk(frameStb == eFrame, "R4 frameStb", int'(frameStb), int'(eFrame));
    chk(preByteStb == ePreByte, "R5 preByteStb", int'(preByteStb), int'(ePreByte));
    chk(preFrameStb == ePreFrame, "R6 preFrameStb", int'(preFrameStb), int'(ePreFrame));
    chk(preSlot == eSlot, "R7 preSlot", int'(preSlot), int'(eSlot));
    chk(sharedPin == ePin, slotPinDisable ? "R9 sharedPin" : "R8 sharedPin",
        int'(sharedPin), int'(ePin));
  endtask

  initial begin
    rst = 1'b1; chipEn = 1'b1; txMode = 1'b0; slotPinDisable = 1'b0; txData = 1'b0;
    modelReset();
    repeat (3) @(negedge clk);
    compareAll("R12 reset count");
    rst = 1'b0;
    for (int i = 0; i < 9000; i++) begin
      bit e, prevMode;
      string tag;
      prevMode = txMode;
      e = (i % 7 != 3) && !(i >= 5000 && i < 5040);
      chipEn         = e;
      rst            = (i == 300 || i == 301);
      txMode         = ((i / 97) % 2) == 1;
      slotPinDisable = ((i / 1300) % 2) == 1;
      txData         = (i % 5) == 0;
      @(posedge clk);
      if (rst)    modelReset();
      else if (e) modelAdvance();
      if (rst)                   tag = "R12 count after reset";
      else if (!e)               tag = "R11 count held";
      else if (txMode != prevMode) tag = "R10 count across mode change";
      else                       tag = "R1 count";
      @(negedge clk);
      compareAll(tag);
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule